// File: doc/BRIEF.md
# Two-Byte Serial Converter Reader

This host-side controller runs in the system clock domain and fetches one 10-bit result from a two-channel serial analog-to-digital converter. A start request carries three choices: the channel, whether the input is single-ended or a pseudo-differential pair, and the idle level of the serial clock. On a start request the controller drives chip-select low and waits a setup interval. It then runs sixteen serial clocks, which is two 8-bit transfers. After a deselect interval it presents the result together with a one-cycle valid strobe.

The command goes out in the first byte behind exactly one leading zero. With this framing the top two result bits land at the bottom of the first received byte and the other eight bits fill the second byte. A bit that the converter drives low in the slot just before the result is checked, and it is reported as a sanity flag. The serial half-period is requested per conversion in system clock cycles. It is clamped from below so that the converter's minimum high and low times are respected. It is clamped from above so that the held sample cannot decay before the conversion finishes.

Top module: `spi_adc_reader`

## Requirements
- R1: The first eight bits sent on `mosi`, most significant first, are 0, 1, `single_end`, `ch_odd`, 1, 0, 0, 0. `single_end`=1 selects single-ended input and 0 selects a pseudo-differential pair. `ch_odd` picks the channel or the polarity. The next eight bits sent are all 0.
- R2: Each conversion produces exactly 16 rising edges on `sclk` while `cs_n` is low. `mosi` changes only while `sclk` is low, and `miso` is sampled at the rising edges. Between conversions `sclk` rests at the `idle_high` level latched at the last accepted start (0 after reset).
- R3: `result` holds the bits sampled at rising edges 7 to 16, most significant first.
- R4: `null_err` is the value sampled at rising edge 6. The converter should drive a 0 there, so a 1 flags a fault.
- R5: Each serial clock half-period lasts H system cycles. H is `half_div` clamped to the range HALF_MIN to HALF_MAX and latched at the start.
- R6: The first rising edge of `sclk` comes exactly SETUP_CYC+H system cycles after `cs_n` falls.
- R7: `busy` is high from the cycle after a start is accepted until the cycle in which `valid` pulses. In that cycle `busy` is low. `cs_n` rises right after the 16th clock and stays high for DESEL_CYC cycles before `valid`, so consecutive conversions are separated by DESEL_CYC+1 high cycles.
- R8: A start request while `busy` is high is ignored. The channel, mode, idle level and divider of the running conversion are unchanged.
- R9: A start request in the same cycle as `valid` is accepted, and `cs_n` falls on the next cycle.
- R10: A synchronous reset, including one in mid-transfer, returns the block to idle with `cs_n` high, `sclk` low, and `busy` and `valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Conversion request, accepted when idle |
| single_end | input | 1 | 1 = single-ended input, 0 = pseudo-differential |
| ch_odd | input | 1 | Channel or polarity select |
| idle_high | input | 1 | 0 = clock idles low (mode 0), 1 = idles high (mode 3) |
| half_div | input | DIV_W | Requested serial half-period in system cycles |
| busy | output | 1 | Conversion in progress |
| valid | output | 1 | One-cycle strobe, result ready |
| result | output | 10 | Converted code |
| null_err | output | 1 | Null slot was not 0 |
| cs_n | output | 1 | Converter chip-select, active low |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to converter |
| miso | input | 1 | Serial data from converter |

## Verification
The end-of-conversion strobe and the acceptance of a new request can fall in the same cycle. To provoke this, the bench holds `start` high through a whole conversion. It then checks three things: `valid` pulses with the correct code, `cs_n` falls on the very next cycle, and the high gap between the two selects is exactly DESEL_CYC+1 cycles. A second coincidence is also tested: a request raised in mid-transfer with every setting flipped. The bench judges it by the returned code, the received command and the half-period, all of which must follow the original settings.

// File: rtl/spi_adc_reader.sv
module spi_adc_reader #(
  parameter int DIV_W     = 12,
  parameter int HALF_MIN  = 16,
  parameter int HALF_MAX  = 3000,
  parameter int SETUP_CYC = 10,
  parameter int DESEL_CYC = 31
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             single_end,
  input  logic             ch_odd,
  input  logic             idle_high,
  input  logic [DIV_W-1:0] half_div,
  output logic             busy,
  output logic             valid,
  output logic [9:0]       result,
  output logic             null_err,
  output logic             cs_n,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso
);
  localparam int WAIT_MAX = (SETUP_CYC > DESEL_CYC) ? SETUP_CYC : DESEL_CYC;
  localparam int WAIT_W   = $clog2(WAIT_MAX + 1);
  localparam logic [DIV_W-1:0]  LO       = DIV_W'(HALF_MIN);
  localparam logic [DIV_W-1:0]  HI       = DIV_W'(HALF_MAX);
  localparam logic [WAIT_W-1:0] SETUP_LAST = WAIT_W'(SETUP_CYC - 1);
  localparam logic [WAIT_W-1:0] DESEL_LAST = WAIT_W'(DESEL_CYC - 1);

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_XFER, S_GAP} st_t;

  st_t               st;
  logic [WAIT_W-1:0] wcnt;
  logic [DIV_W-1:0]  dcnt;
  logic [DIV_W-1:0]  half_q;
  logic [4:0]        hc;
  logic [15:0]       cmd_q;
  logic [10:0]       rx;
  logic              pol_q;

  wire [DIV_W-1:0] half_eff = (half_div < LO) ? LO : (half_div > HI) ? HI : half_div;
  wire             half_end = (dcnt == half_q - 1'b1);

  assign busy = (st != S_IDLE);
  assign cs_n = !(st == S_SETUP || st == S_XFER);
  assign sclk = (st == S_XFER) ? hc[0] : pol_q;
  assign mosi = (st == S_XFER) ? cmd_q[~hc[4:1]] : 1'b0;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      wcnt     <= '0;
      dcnt     <= '0;
      hc       <= '0;
      half_q   <= LO;
      cmd_q    <= '0;
      rx       <= '0;
      pol_q    <= 1'b0;
      valid    <= 1'b0;
      result   <= '0;
      null_err <= 1'b0;
    end else begin
      valid <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st     <= S_SETUP;
          wcnt   <= '0;
          half_q <= half_eff;
          pol_q  <= idle_high;
          cmd_q  <= {1'b0, 1'b1, single_end, ch_odd, 1'b1, 3'b000, 8'h00};
        end
        S_SETUP: if (wcnt == SETUP_LAST) begin
          st   <= S_XFER;
          hc   <= '0;
          dcnt <= '0;
        end else begin
          wcnt <= wcnt + 1'b1;
        end
        S_XFER: if (half_end) begin
          dcnt <= '0;
          if (!hc[0]) rx <= {rx[9:0], miso};
          if (hc == 5'd31) begin
            st   <= S_GAP;
            wcnt <= '0;
          end else begin
            hc <= hc + 5'd1;
          end
        end else begin
          dcnt <= dcnt + 1'b1;
        end
        S_GAP: if (wcnt == DESEL_LAST) begin
          st       <= S_IDLE;
          valid    <= 1'b1;
          result   <= rx[9:0];
          null_err <= rx[10];
        end else begin
          wcnt <= wcnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [WAIT_W:0] hi_run;
  logic            sel_seen;
  localparam logic [WAIT_W:0] DESEL_MIN = (WAIT_W+1)'(DESEL_CYC);

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_run   <= '0;
      sel_seen <= 1'b0;
    end else begin
      if (!cs_n) begin
        hi_run   <= '0;
        sel_seen <= 1'b1;
      end else if (!(&hi_run)) begin
        hi_run <= hi_run + 1'b1;
      end
    end
  end

  // R7
  valid_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
    valid |-> (!busy && $past(busy)));

  // R7
  desel_gap_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(cs_n) && sel_seen) |-> (hi_run >= DESEL_MIN));

  // R2
  mosi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && sclk && $past(sclk)) |-> $stable(mosi));

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(cmd_q) && $stable(half_q) && $stable(pol_q)));

  // R9
  start_accept_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));
endmodule

// File: tb/tb_spi_adc_reader.sv
module tb_spi_adc_reader;
  localparam int DIV_W = 12;
  localparam int HMIN  = 16;
  localparam int HMAX  = 3000;
  localparam int SETUP = 10;
  localparam int DESEL = 31;

  // {idle_high, single_end, ch_odd, half_div[11:0], code[9:0]}
  localparam logic [24:0] VEC [0:5] = '{
    {1'b0, 1'b1, 1'b0, 12'd16, 10'h2A5},
    {1'b0, 1'b1, 1'b1, 12'd20, 10'h15A},
    {1'b1, 1'b1, 1'b0, 12'd16, 10'h3FF},
    {1'b1, 1'b0, 1'b1, 12'd17, 10'h000},
    {1'b0, 1'b0, 1'b0, 12'd3,  10'h201},
    {1'b1, 1'b0, 1'b0, 12'd24, 10'h1C3}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic single_end = 1'b0;
  logic ch_odd = 1'b0;
  logic idle_high = 1'b0;
  logic [DIV_W-1:0] half_div = 12'd16;
  logic miso = 1'b1;
  logic busy, valid, null_err, cs_n, sclk, mosi;
  logic [9:0] result;

  always #5 clk = ~clk;

  spi_adc_reader #(.DIV_W(DIV_W), .HALF_MIN(HMIN), .HALF_MAX(HMAX),
                   .SETUP_CYC(SETUP), .DESEL_CYC(DESEL)) dut (
    .clk(clk), .rst(rst), .start(start), .single_end(single_end),
    .ch_odd(ch_odd), .idle_high(idle_high), .half_div(half_div),
    .busy(busy), .valid(valid), .result(result), .null_err(null_err),
    .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso));

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // converter model and timing monitor, all sampled between clock edges
  logic [9:0]  mcode [0:3];
  logic        force_null = 1'b0;
  logic [15:0] cap = '0;
  int rcount = 0, cyc_low = 0, first_rise_at = 0, hi_len = 0, last_hi = 0;
  int gap_run = 0, gap_len = 0;
  logic cs_prev = 1'b1, sclk_prev = 1'b0, m_sgl = 1'b0, m_odd = 1'b0;

  always @(negedge clk) begin
    if (cs_n) begin
      if (!cs_prev) gap_run = 0;
      gap_run++;
    end else if (cs_prev) begin
      gap_len = gap_run; rcount = 0; cap = '0; cyc_low = 1;
      last_hi = 0; first_rise_at = 0; hi_len = 0;
    end else begin
      cyc_low++;
      if (sclk && !sclk_prev) begin
        rcount++;
        cap = {cap[14:0], mosi};
        if (rcount == 4) begin m_sgl = cap[1]; m_odd = cap[0]; end
        if (rcount == 1) first_rise_at = cyc_low;
        hi_len = 1;
      end else if (sclk) begin
        hi_len++;
      end
      if (!sclk && sclk_prev) begin
        if (rcount > 0) last_hi = hi_len;
        if (rcount < 5)       miso = 1'b1;
        else if (rcount == 5) miso = force_null;
        else if (rcount <= 15) miso = mcode[{m_sgl, m_odd}][15 - rcount];
        else                  miso = 1'b0;
      end
    end
    cs_prev = cs_n;
    sclk_prev = sclk;
  end

  function automatic int clampf(input int d);
    return (d < HMIN) ? HMIN : (d > HMAX) ? HMAX : d;
  endfunction

  task automatic wait_valid(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (valid) begin ok = 1'b1; break; end
    end
  endtask

  task automatic load_model(input int code, input bit nul);
    for (int i = 0; i < 4; i++) mcode[i] = 10'((code + i * 37) % 1024);
    force_null = nul;
  endtask

  task automatic run(input bit pol, input bit sgl, input bit odd, input int div,
                     input int code, input bit nul, input int poke);
    int h;
    bit ok;
    logic [15:0] ecmd;
    logic [9:0] ecode;
    h = clampf(div);
    load_model(code, nul);
    ecode = mcode[{sgl, odd}];
    ecmd = {1'b0, 1'b1, sgl, odd, 1'b1, 3'b000, 8'h00};
    @(negedge clk);
    idle_high = pol; single_end = sgl; ch_odd = odd; half_div = DIV_W'(div); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1 && cs_n == 1'b0, "R7 busy after start", busy, 1);
    if (poke > 0) begin
      repeat (poke) @(negedge clk);
      idle_high = ~pol; single_end = ~sgl; ch_odd = ~odd; half_div = 12'd40; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R8 still busy", busy, 1);
    end
    wait_valid(ok);
    chk(ok, "R7 valid seen", ok, 1);
    chk(result == ecode, "R3 result", result, ecode);
    chk(null_err == nul, "R4 null flag", null_err, nul);
    chk(cap == ecmd, "R1 command", cap, ecmd);
    chk(rcount == 16, "R2 clock count", rcount, 16);
    chk(sclk == pol, "R2 idle level", sclk, pol);
    chk(last_hi == h, "R5 half period", last_hi, h);
    // rise is seen at sample SETUP+H+1 counting the cs fall sample as 1
    chk(first_rise_at == SETUP + h + 1, "R6 setup", first_rise_at, SETUP + h + 1);
    chk(busy == 1'b0 && cs_n == 1'b1, "R7 idle at valid", busy, 0);
  endtask

  initial begin
    bit ok;
    logic [9:0] e2;
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1 && busy == 1'b0 && valid == 1'b0, "R10 reset state", cs_n, 1);
    rst = 1'b0;
    @(negedge clk);
    chk(sclk == 1'b0 && mosi == 1'b0 && cs_n == 1'b1, "R10 after release", sclk, 0);

    for (int i = 0; i < 6; i++)
      run(VEC[i][24], VEC[i][23], VEC[i][22], int'(VEC[i][21:10]), int'(VEC[i][9:0]), 1'b0, 0);

    // R8: request in mid-transfer with every setting flipped
    run(1'b0, 1'b1, 1'b0, 16, 10'h0F0, 1'b0, 200);

    // R4: faulty null slot
    run(1'b1, 1'b1, 1'b1, 16, 10'h333, 1'b1, 0);

    // R9: start held across the valid strobe
    load_model(10'h155, 1'b0);
    e2 = mcode[3];
    @(negedge clk);
    idle_high = 1'b0; single_end = 1'b1; ch_odd = 1'b1; half_div = 12'd16; start = 1'b1;
    wait_valid(ok);
    chk(ok && cs_n == 1'b1, "R9 valid with start", cs_n, 1);
    chk(result == e2, "R9 first result", result, e2);
    @(negedge clk);
    chk(cs_n == 1'b0 && busy == 1'b1, "R9 restart next cycle", cs_n, 0);
    start = 1'b0;
    wait_valid(ok);
    chk(ok && result == e2, "R9 second result", result, e2);
    chk(gap_len == DESEL + 1, "R7 deselect gap", gap_len, DESEL + 1);

    // R5 upper clamp, then R10 reset in mid-transfer
    @(negedge clk);
    idle_high = 1'b0; half_div = 12'd4095; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (SETUP + 2 * HMAX + 20) @(negedge clk);
    chk(last_hi == HMAX, "R5 upper clamp", last_hi, HMAX);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(cs_n == 1'b1 && busy == 1'b0 && sclk == 1'b0 && valid == 1'b0,
        "R10 mid-transfer reset", busy, 0);
    run(1'b0, 1'b0, 1'b1, 18, 10'h2C8, 1'b0, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule